// File: doc/BRIEF.md
# Speculative Memory Dependence Validator

This block is the memory side of a software-style speculation scheme. Parallel workers send loads and stores, each tagged with a small timestamp equal to the worker's position in the current chunk of loop iterations. The block keeps the newest data in its own data array and returns load data straight away. One cycle later it checks the access against a small direct-mapped table of per-location read and write stamps. An access that breaks sequential order raises an abort flag.

The first time a chunk touches a location, the block claims a table entry and pushes the entry index and the location's pre-chunk value onto an undo log. At the end of a chunk the controller pulses either commit or rollback. Commit walks the log and frees every entry it names, leaving the data as written. Rollback walks the log, writes each saved value back to its address, and frees the entries. Either walk ends with a one-cycle done pulse. A rollback also clears the abort flag.

Top module: `spec_mem_validator`

## Requirements
- R1: After reset the request port is ready, abort and done are low, no response is valid, and every data word reads as zero.
- R2: A load accepted at edge k returns the data array's current word for its address on the response port after edge k, for exactly one cycle. This holds whatever the outcome of its check.
- R3: A load whose stamp is equal to or later than the location's last-write stamp is in order and raises the last-read stamp to the larger of the two. An earlier stamp sets abort after the edge that follows the accepting edge.
- R4: A store whose stamp is earlier than the location's last-read stamp sets abort and leaves the data unchanged.
- R5: A store that passes the read check but is earlier than the last-write stamp is dropped without effect. Any other passing store writes the data and sets the last-write stamp; equal stamps count as in order.
- R6: The table index is the XOR of address bits [2:0] and [5:3] (default widths). An access whose index is held by a different address sets abort.
- R7: The first access to a location within a chunk claims its entry and logs the entry index and the original data. An access that needs a new entry when the log already holds LOG_DEPTH (default 4) entries sets abort.
- R8: Abort is sticky. While it is set, the request port is not ready and commit is ignored.
- R9: Commit with N logged entries pulses done for one cycle after the (N+1)th edge following the edge that sampled it. The data is kept, and all stamps and entries are freed for the next chunk.
- R10: Rollback with N logged entries restores every logged location to its pre-chunk value, frees the entries, pulses done after the (N+1)th edge, and clears abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Store data |
| req_ts_i | input | TS_W | Requester timestamp |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_rdata_o | output | DATA_W | Load data |
| commit_i | input | 1 | Start commit walk |
| rollback_i | input | 1 | Start rollback walk (wins over commit) |
| walk_done_o | output | 1 | One-cycle pulse at walk end |
| abort_o | output | 1 | Sticky miss-speculation flag |

## Verification
The assertions assume the following about the inputs. A request is held only until the edge that accepts it. Commit and rollback are single-cycle pulses given while no request is being checked. The log is therefore never pushed while it is popped. The stimulus drives every input on the falling edge and waits for each check to finish before it issues the next request. It raises a chunk-control pulse only when the port is idle, so these conditions always hold.

// File: rtl/mdv_pkg.sv
package mdv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WALK} mdv_state_e;
endpackage

// File: rtl/mdv_hash.sv
module mdv_hash #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int NCH   = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] pad;
  logic [NCH-1:0][IDX_W-1:0] chunk;

  assign pad = PAD_W'(addr_i);

  for (genvar g = 0; g < NCH; g++) begin : g_slice
    assign chunk[g] = pad[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NCH; i++) idx_o = idx_o ^ chunk[i];
  end
endmodule

// File: rtl/mdv_ts_table.sv
module mdv_ts_table #(
  parameter int ADDR_W = 6,
  parameter int TS_W   = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic              a_vld_o,
  output logic [ADDR_W-1:0] a_tag_o,
  output logic [TS_W-1:0]   a_rd_o,
  output logic [TS_W-1:0]   a_wr_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [ADDR_W-1:0] b_tag_o,
  input  logic              set_en_i,
  input  logic [ADDR_W-1:0] set_tag_i,
  input  logic [TS_W-1:0]   set_rd_i,
  input  logic [TS_W-1:0]   set_wr_i,
  input  logic              clr_en_i
);
  localparam int ENT = 1 << IDX_W;

  logic              vld_q [ENT];
  logic [ADDR_W-1:0] tag_q [ENT];
  logic [TS_W-1:0]   rd_q  [ENT];
  logic [TS_W-1:0]   wr_q  [ENT];

  assign a_vld_o = vld_q[a_idx_i];
  assign a_tag_o = tag_q[a_idx_i];
  assign a_rd_o  = rd_q[a_idx_i];
  assign a_wr_o  = wr_q[a_idx_i];
  assign b_tag_o = tag_q[b_idx_i];

  // set uses port a index, clear uses port b index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENT; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        rd_q[i]  <= '0;
        wr_q[i]  <= '0;
      end
    end else if (set_en_i) begin
      vld_q[a_idx_i] <= 1'b1;
      tag_q[a_idx_i] <= set_tag_i;
      rd_q[a_idx_i]  <= set_rd_i;
      wr_q[a_idx_i]  <= set_wr_i;
    end else if (clr_en_i) begin
      vld_q[b_idx_i] <= 1'b0;
      rd_q[b_idx_i]  <= '0;
      wr_q[b_idx_i]  <= '0;
    end
  end

  p_clear_frees_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> !vld_q[$past(b_idx_i)]);
endmodule

// File: rtl/mdv_undo_log.sv
module mdv_undo_log #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_idx_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [IDX_W-1:0]  top_idx_o,
  output logic [DATA_W-1:0] top_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IDX_W-1:0]  idx_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_ptr;
  logic [PTR_W-1:0]  wr_ptr;

  assign top_ptr    = PTR_W'(cnt_q - 1'b1);
  assign wr_ptr     = PTR_W'(cnt_q);
  assign top_idx_o  = idx_q[top_ptr];
  assign top_data_o = dat_q[top_ptr];
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign empty_o    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        idx_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (push_i) begin
      idx_q[wr_ptr] <= push_idx_i;
      dat_q[wr_ptr] <= push_data_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_push_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o && !pop_i));
  p_pop_not_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spec_mem_validator.sv
module spec_mem_validator
  import mdv_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int TS_W      = 4,
  parameter int IDX_W     = 3,
  parameter int LOG_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [TS_W-1:0]   req_ts_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              commit_i,
  input  logic              rollback_i,
  output logic              walk_done_o,
  output logic              abort_o
);
  localparam int WORDS = 1 << ADDR_W;

  mdv_state_e        state_q;
  logic              p_write_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;
  logic [TS_W-1:0]   p_ts_q;
  logic              walk_rb_q, abort_q, done_q, rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic [DATA_W-1:0] mem_q [WORDS];

  logic [IDX_W-1:0]  chk_idx;
  logic              e_vld;
  logic [ADDR_W-1:0] e_tag, walk_tag;
  logic [TS_W-1:0]   e_rd, e_wr, cur_rd, cur_wr, new_rd, new_wr;
  logic [IDX_W-1:0]  log_top_idx;
  logic [DATA_W-1:0] log_top_data;
  logic              log_full, log_empty;
  logic              hit, chk_bad, chk_tbl_we, chk_mem_we;
  logic              in_check, alloc_go, tbl_we, walk_pop, accept;

  mdv_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i(p_addr_q), .idx_o(chk_idx)
  );

  mdv_ts_table #(.ADDR_W(ADDR_W), .TS_W(TS_W), .IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .a_idx_i(chk_idx), .a_vld_o(e_vld), .a_tag_o(e_tag), .a_rd_o(e_rd), .a_wr_o(e_wr),
    .b_idx_i(log_top_idx), .b_tag_o(walk_tag),
    .set_en_i(tbl_we), .set_tag_i(p_addr_q), .set_rd_i(new_rd), .set_wr_i(new_wr),
    .clr_en_i(walk_pop)
  );

  mdv_undo_log #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk_i, .rst_ni,
    .push_i(alloc_go), .push_idx_i(chk_idx), .push_data_i(mem_q[p_addr_q]),
    .pop_i(walk_pop), .top_idx_o(log_top_idx), .top_data_o(log_top_data),
    .full_o(log_full), .empty_o(log_empty)
  );

  // timestamp-ordering verdict for the pending request
  always_comb begin
    hit        = e_vld && (e_tag == p_addr_q);
    cur_rd     = hit ? e_rd : '0;
    cur_wr     = hit ? e_wr : '0;
    new_rd     = cur_rd;
    new_wr     = cur_wr;
    chk_bad    = 1'b0;
    chk_tbl_we = 1'b0;
    chk_mem_we = 1'b0;
    if (e_vld && !hit) begin
      chk_bad = 1'b1;
    end else if (!e_vld && log_full) begin
      chk_bad = 1'b1;
    end else if (!p_write_q) begin
      if (p_ts_q < cur_wr) chk_bad = 1'b1;
      else begin
        chk_tbl_we = 1'b1;
        if (p_ts_q > cur_rd) new_rd = p_ts_q;
      end
    end else begin
      if (p_ts_q < cur_rd) chk_bad = 1'b1;
      else if (p_ts_q >= cur_wr) begin
        chk_tbl_we = 1'b1;
        chk_mem_we = 1'b1;
        new_wr     = p_ts_q;
      end
    end
  end

  assign in_check    = (state_q == ST_CHECK);
  assign alloc_go    = in_check && !e_vld && !chk_bad;
  assign tbl_we      = in_check && chk_tbl_we;
  assign walk_pop    = (state_q == ST_WALK) && !log_empty;
  assign req_ready_o = (state_q == ST_IDLE) && !abort_q && !commit_i && !rollback_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      p_write_q   <= 1'b0;
      p_addr_q    <= '0;
      p_wdata_q   <= '0;
      p_ts_q      <= '0;
      walk_rb_q   <= 1'b0;
      abort_q     <= 1'b0;
      done_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      done_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rollback_i) begin
            walk_rb_q <= 1'b1;
            state_q   <= ST_WALK;
          end else if (commit_i && !abort_q) begin
            walk_rb_q <= 1'b0;
            state_q   <= ST_WALK;
          end else if (accept) begin
            p_write_q   <= req_write_i;
            p_addr_q    <= req_addr_i;
            p_wdata_q   <= req_wdata_i;
            p_ts_q      <= req_ts_i;
            rsp_rdata_q <= mem_q[req_addr_i];
            rsp_valid_q <= !req_write_i;
            state_q     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (chk_bad) abort_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WALK: begin
          if (log_empty) begin
            done_q  <= 1'b1;
            if (walk_rb_q) abort_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (in_check && chk_mem_we) begin
      mem_q[p_addr_q] <= p_wdata_q;
    end else if (walk_pop && walk_rb_q) begin
      mem_q[walk_tag] <= log_top_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign walk_done_o = done_q;
  assign abort_o     = abort_q;

  p_abort_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !req_ready_o);
  p_abort_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(abort_q) |-> $past(state_q == ST_WALK && walk_rb_q));
  p_load_rsp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(accept && !req_write_i));
  p_done_after_walk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done_o |-> ($past(state_q == ST_WALK) && log_empty));
  p_stale_store_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_check && p_write_q && hit && p_ts_q >= e_rd && p_ts_q < e_wr)
      |=> mem_q[p_addr_q] == $past(mem_q[p_addr_q]));
endmodule

// File: tb/spec_mem_validator_test.sv
`timescale 1ns/1ps
module spec_mem_validator_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  req_ts = '0;
  logic        commit = 1'b0, rollback = 1'b0;
  logic        req_ready, rsp_valid, walk_done, abort;
  logic [15:0] rsp_rdata;

  always #10 clk = ~clk;

  spec_mem_validator uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ts_i(req_ts),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .commit_i(commit), .rollback_i(rollback),
    .walk_done_o(walk_done), .abort_o(abort)
  );

  int errs = 0, checks = 0;
  bit finished = 0;

  // reference model state
  int m_mem [64];
  bit m_v [8];
  int m_tag [8], m_rd [8], m_wr [8];
  int lq_idx [$], lq_dat [$];
  bit m_abort = 0;

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int hidx(int a);
    return (a & 7) ^ ((a >> 3) & 7);
  endfunction

  task automatic do_req(bit wr, int addr, int data, int ts, string rq);
    int h, crd, cwr, old;
    bit bad, hit;
    if (m_abort) begin
      chk(rq, "ready while aborted", int'(req_ready), 0);
      return;
    end
    h   = hidx(addr);
    old = m_mem[addr];
    hit = m_v[h] && m_tag[h] == addr;
    bad = 0;
    crd = hit ? m_rd[h] : 0;
    cwr = hit ? m_wr[h] : 0;
    if (m_v[h] && !hit) bad = 1;
    else if (!m_v[h] && lq_idx.size() == 4) bad = 1;
    else if (!wr) bad = (ts < cwr);
    else bad = (ts < crd);
    if (bad) m_abort = 1;
    else begin
      if (!m_v[h]) begin
        lq_idx.push_back(h); lq_dat.push_back(old);
        m_v[h] = 1; m_tag[h] = addr; m_rd[h] = 0; m_wr[h] = 0;
      end
      if (!wr) begin
        if (ts > m_rd[h]) m_rd[h] = ts;
      end else if (ts >= m_wr[h]) begin
        m_mem[addr] = data; m_wr[h] = ts;
      end
    end
    chk(rq, "ready before request", int'(req_ready), 1);
    req_valid = 1; req_write = wr; req_addr = 6'(addr); req_wdata = 16'(data); req_ts = 4'(ts);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", int'(rsp_valid), wr ? 0 : 1);
    if (!wr) chk(rq, "load data", int'(rsp_rdata), old);
    @(posedge clk);
    @(negedge clk);
    chk(rq, "abort after check", int'(abort), int'(m_abort));
  endtask

  task automatic do_walk(bit rb, string rq);
    int n, cyc;
    if (!rb && m_abort) begin
      commit = 1;
      @(negedge clk);
      commit = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(rq, "done on ignored commit", int'(walk_done), 0);
      end
      chk(rq, "abort held", int'(abort), 1);
      return;
    end
    n = lq_idx.size();
    if (rb) rollback = 1; else commit = 1;
    @(negedge clk);
    rollback = 0; commit = 0;
    cyc = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (walk_done) break;
    end
    chk(rq, "walk cycles", cyc, n + 1);
    foreach (lq_idx[i]) begin
      if (rb) m_mem[m_tag[lq_idx[i]]] = lq_dat[i];
      m_v[lq_idx[i]] = 0; m_rd[lq_idx[i]] = 0; m_wr[lq_idx[i]] = 0;
    end
    lq_idx.delete(); lq_dat.delete();
    if (rb) m_abort = 0;
    chk(rq, "abort after walk", int'(abort), int'(m_abort));
    @(negedge clk);
    chk(rq, "done is one cycle", int'(walk_done), 0);
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_mem[i] = 0;
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_tag[i] = 0; m_rd[i] = 0; m_wr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "abort", int'(abort), 0);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "done", int'(walk_done), 0);
    // chunk A
    do_req(0, 5, 0, 2, "R1_R2");
    do_req(1, 5, 'h111, 3, "R5");
    do_req(0, 5, 0, 3, "R3");
    do_req(0, 5, 0, 6, "R3");
    do_req(1, 2, 'h222, 4, "R7");
    do_req(1, 2, 'h333, 1, "R5");
    do_req(0, 2, 0, 7, "R5");
    do_walk(0, "R9");
    // chunk B
    do_req(0, 5, 0, 0, "R9");
    do_req(1, 5, 'h444, 1, "R5");
    do_req(0, 2, 0, 5, "R3");
    do_req(1, 2, 'h555, 3, "R4");
    do_req(0, 2, 0, 6, "R8");
    do_walk(0, "R8");
    do_walk(1, "R10");
    // chunk C
    do_req(0, 5, 0, 0, "R10");
    do_req(0, 2, 0, 0, "R10");
    do_req(1, 0, 7, 1, "R5");
    do_req(0, 9, 0, 2, "R6");
    do_walk(1, "R10");
    // chunk D
    do_req(0, 0, 0, 0, "R10");
    do_req(1, 3, 9, 5, "R5");
    do_req(0, 3, 0, 1, "R3");
    do_walk(1, "R10");
    // chunk E
    for (int a = 0; a < 4; a++) do_req(0, a, 0, a, "R7");
    do_req(0, 4, 0, 4, "R7");
    do_walk(1, "R10");
    do_walk(0, "R9");
    do_req(0, 3, 0, 0, "R10");
    do_walk(0, "R9");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule